// File: doc/BRIEF.md
# Vector Sum Reduction Engine

This block adds up an arbitrarily long stream of unsigned integers without building a single serial accumulator chain. The caller first gives the element count N through a start handshake. The data then arrives in chunks that are VL lanes wide. Each accepted chunk is added lane by lane into VL independent partial sums, so consecutive chunks never wait on one another.

When N is not a multiple of VL, the leftover elements come first, as a short chunk that fills only the low lanes. All later chunks are full. After the final chunk the engine folds the partial-sum vector onto itself. On each cycle the upper half of the still-active lanes is added into the lower half, until lane 0 holds the grand total. The total is then offered on a valid/ready result port. It stays there until the consumer takes it, and only after that is a new job accepted.

Sums are kept at twice the input width and wrap on overflow. VL must be a power of two and at least two.

Top module: `vred_engine`

## Requirements
- R1: After reset, start_ready is 1, in_ready is 0 and res_valid is 0.
- R2: A job starts on a cycle with start_valid and start_ready both high, and captures start_len as N. All partial sums are zeroed at that point, so no earlier job affects the result.
- R3: When N mod VL is r and r is not zero, the first chunk uses only lanes 0 to r-1. Whatever sits in lanes r to VL-1 of that chunk contributes nothing to the result.
- R4: Every chunk after the first carries VL elements. Exactly ceil(N/VL) chunks are accepted, and in_ready is low in the cycle after the last one.
- R5: When N is 0, no chunk is accepted and the result is 0.
- R6: res_data equals the sum of all N elements modulo 2^(2W). Element i of a chunk is the unsigned value in_data[i*W +: W].
- R7: res_valid rises exactly log2(VL) clock edges after the edge that accepted the last chunk. For N = 0 it counts from the start edge.
- R8: While res_valid is high and res_ready is low, res_valid stays high and res_data stays unchanged. The edge that sees both high drops res_valid and restores start_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_valid | input | 1 | Caller offers a new job |
| start_len | input | LEN_W | Element count N of the job |
| start_ready | output | 1 | Engine idle, can take a job |
| in_valid | input | 1 | A data chunk is offered |
| in_data | input | VL*W | Chunk, lane i at bits i*W +: W |
| in_ready | output | 1 | Engine takes chunks |
| res_valid | output | 1 | Total is available |
| res_data | output | 2*W | Total modulo 2^(2W) |
| res_ready | input | 1 | Consumer takes the total |

## Verification
A lane that keeps a stale value from an earlier job, or that adds masked-off data, shows up as a wrong total at the very next result. The scoreboard catches it because every job compares against a freshly computed sequential sum. Jobs with nonzero upper-lane filler in the short chunk make the masking error visible. A wrong chunk or step count shows in the ports instead: in_ready may stay high after the expected last chunk, or res_valid may appear on the wrong cycle. Both are checked on the first cycle where they can differ.

// File: rtl/vred_pkg.sv
// Shared types of the vector sum reduction engine.
package vred_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a job
        ST_ACC  = 2'd1,   // taking chunks
        ST_RED  = 2'd2,   // halving passes
        ST_DONE = 2'd3    // total offered
    } vred_state_e;
endpackage

// File: rtl/vred_ctrl.sv
// Job sequencer: accepts a job, counts chunks (short remainder chunk first),
// then steps through log2(VL) halving passes and holds the result handshake.
// Assumes VL is a power of two, VL >= 2.
module vred_ctrl
    import vred_pkg::*;
#(
    parameter int VL    = 8,
    parameter int LEN_W = 20,
    parameter int CW    = $clog2(VL + 1),
    parameter int SW    = ($clog2(VL) > 0) ? $clog2(VL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_valid,
    input  logic [LEN_W-1:0] start_len,
    output logic             start_ready,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             res_valid,
    input  logic             res_ready,
    output logic             clr,
    output logic             add_en,
    output logic [CW-1:0]    chunk_len,
    output logic             red_en,
    output logic [SW-1:0]    red_step
);
    localparam int LOG = $clog2(VL);

    vred_state_e      state;
    logic [LEN_W-1:0] remain;
    logic [CW-1:0]    chunk_q;
    logic [SW-1:0]    step_q;
    logic [CW-1:0]    first_len;
    logic [LOG-1:0]   len_mod;

    // Length of the first chunk: the remainder, or a full chunk when none.
    always_comb begin
        len_mod   = start_len[LOG-1:0];
        first_len = (len_mod == '0) ? CW'(VL) : CW'(len_mod);
    end

    // Handshake and datapath strobes decoded from the state.
    always_comb begin
        start_ready = (state == ST_IDLE);
        in_ready    = (state == ST_ACC);
        res_valid   = (state == ST_DONE);
        clr         = start_valid && start_ready;
        add_en      = in_valid && in_ready;
        chunk_len   = chunk_q;
        red_en      = (state == ST_RED);
        red_step    = step_q;
    end

    // Sequencer state, remaining element count and pass counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            remain  <= '0;
            chunk_q <= '0;
            step_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_valid) begin
                    remain  <= start_len;
                    chunk_q <= first_len;
                    step_q  <= '0;
                    state   <= (start_len == '0) ? ST_RED : ST_ACC;
                end
                ST_ACC: if (in_valid) begin
                    remain  <= remain - LEN_W'(chunk_q);
                    chunk_q <= CW'(VL);
                    if (remain == LEN_W'(chunk_q)) state <= ST_RED;
                end
                ST_RED: begin
                    step_q <= step_q + 1'b1;
                    if (step_q == SW'(LOG - 1)) state <= ST_DONE;
                end
                ST_DONE: if (res_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_ready, in_ready, res_valid}));
    // R4
    chunk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |-> (chunk_len != '0) && (chunk_len <= CW'(VL)));
    // R8
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid);
    // R8
    res_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_ready |=> !res_valid && start_ready);
endmodule

// File: rtl/vred_lanes.sv
// Partial-sum bank: VL accumulators of AW bits. Clears on job start, adds a
// masked chunk lane by lane, and on each reduction pass adds the upper half
// of the active lanes into the lower half. Lane 0 holds the total at the end.
module vred_lanes #(
    parameter int VL = 8,
    parameter int W  = 16,
    parameter int AW = 2 * W,
    parameter int CW = $clog2(VL + 1),
    parameter int SW = ($clog2(VL) > 0) ? $clog2(VL) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            add_en,
    input  logic [CW-1:0]   chunk_len,
    input  logic [VL*W-1:0] in_data,
    input  logic            red_en,
    input  logic [SW-1:0]   red_step,
    output logic [AW-1:0]   sum_out
);
    localparam int LOG  = $clog2(VL);
    localparam int NSEL = 1 << SW;

    logic [AW-1:0] acc [VL];

    for (genvar i = 0; i < VL; i++) begin : g_lane
        logic [AW-1:0] cand [NSEL];
        logic [AW-1:0] partner;
        logic          lane_on;

        // Candidate partner per pass: lane i+VL/2^(k+1) when i is in the lower half.
        for (genvar k = 0; k < NSEL; k++) begin : g_pass
            if (k < LOG && i < (VL >> (k + 1))) begin : g_take
                assign cand[k] = acc[i + (VL >> (k + 1))];
            end else begin : g_none
                assign cand[k] = '0;
            end
        end

        // Select the partner for the current pass and the chunk lane mask.
        always_comb begin
            partner = cand[red_step];
            lane_on = (CW'(i) < chunk_len);
        end

        // Accumulator update: clear, add chunk lane, or fold in partner.
        always_ff @(posedge clk) begin
            if (!rst_n)                  acc[i] <= '0;
            else if (clr)                acc[i] <= '0;
            else if (add_en && lane_on)  acc[i] <= acc[i] + AW'(in_data[i*W +: W]);
            else if (red_en)             acc[i] <= acc[i] + partner;
        end
    end

    assign sum_out = acc[0];

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc[0] == '0) && (acc[VL-1] == '0));
    // R3
    masked_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add_en && (chunk_len == CW'(1)) && !clr |=> $stable(acc[VL-1]));
endmodule

// File: rtl/vred_engine.sv
// Top of the vector sum reduction engine: joins the sequencer and the
// partial-sum bank. Job length in, VL-wide chunks in, one total out.
module vred_engine #(
    parameter int W     = 16,
    parameter int VL    = 8,
    parameter int LEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_valid,
    input  logic [LEN_W-1:0] start_len,
    output logic             start_ready,
    input  logic             in_valid,
    input  logic [VL*W-1:0]  in_data,
    output logic             in_ready,
    output logic             res_valid,
    output logic [2*W-1:0]   res_data,
    input  logic             res_ready
);
    localparam int AW = 2 * W;
    localparam int CW = $clog2(VL + 1);
    localparam int SW = ($clog2(VL) > 0) ? $clog2(VL) : 1;

    logic          clr, add_en, red_en;
    logic [CW-1:0] chunk_len;
    logic [SW-1:0] red_step;
    logic [AW-1:0] sum_w;

    vred_ctrl #(.VL(VL), .LEN_W(LEN_W), .CW(CW), .SW(SW)) u_ctrl (
        .clk, .rst_n, .start_valid, .start_len, .start_ready,
        .in_valid, .in_ready, .res_valid, .res_ready,
        .clr, .add_en, .chunk_len, .red_en, .red_step
    );

    vred_lanes #(.VL(VL), .W(W), .AW(AW), .CW(CW), .SW(SW)) u_lanes (
        .clk, .rst_n, .clr, .add_en, .chunk_len, .in_data,
        .red_en, .red_step, .sum_out(sum_w)
    );

    assign res_data = sum_w;

    // R8
    res_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> $stable(res_data));
    // R4
    no_chunk_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !in_ready);
endmodule

// File: tb/sim_vred_engine.sv
// Scoreboard bench: the driver pushes the expected total and result edge,
// and the monitor pops and compares them when the result appears.
module sim_vred_engine;
    localparam int W = 16, VL = 8, LEN_W = 20, LOG = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_valid = 1'b0;
    logic [LEN_W-1:0] start_len = '0;
    logic start_ready;
    logic in_valid = 1'b0;
    logic [VL*W-1:0] in_data = '0;
    logic in_ready;
    logic res_valid;
    logic [2*W-1:0] res_data;
    logic res_ready = 1'b0;

    int n_tests = 0, n_fail = 0, cyc = 0, mon_cnt = 0;
    logic [2*W-1:0] exp_q[$];
    int edge_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vred_engine #(.W(W), .VL(VL), .LEN_W(LEN_W)) u0 (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] elem(input int job, input int k, input bit ones);
        return ones ? {W{1'b1}} : W'(k * 40503 + job * 977 + 13);
    endfunction

    task automatic run_job(input int job, input int n, input bit ones);
        logic [2*W-1:0] sum = '0;
        int start_edge, last_edge, idx, len, first;
        @(negedge clk);
        start_valid = 1'b1; start_len = LEN_W'(n);
        while (!start_ready) @(negedge clk);
        start_edge = cyc + 1;
        @(negedge clk);
        start_valid = 1'b0;
        last_edge = start_edge;
        first = (n % VL != 0) ? n % VL : VL;
        idx = 0;
        while (idx < n) begin
            len = (idx == 0) ? first : VL;
            for (int l = 0; l < VL; l++) begin
                if (l < len) begin
                    in_data[l*W +: W] = elem(job, idx + l, ones);
                    sum = sum + (2*W)'(elem(job, idx + l, ones));
                end else begin
                    in_data[l*W +: W] = 16'hDEA0 | W'(l);  // R3 filler
                end
            end
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            last_edge = cyc + 1;
            idx += len;
            @(negedge clk);
        end
        in_valid = 1'b0;
        // R4 / R5: no further chunk taken
        chk(in_ready == 1'b0, "R4/R5 in_ready after last chunk", in_ready, 0);
        exp_q.push_back(sum);
        edge_q.push_back(last_edge + LOG);
    endtask

    // Monitor: compare total, result edge, hold behaviour and release.
    initial begin
        logic [2*W-1:0] e;
        int ed, hold;
        forever begin
            @(negedge clk);
            if (rst_n && res_valid) begin
                e = exp_q.pop_front();
                ed = edge_q.pop_front();
                chk(res_data == e, "R6 total", res_data, e);
                chk(cyc == ed, "R7 result edge", cyc, ed);
                hold = mon_cnt % 3;
                mon_cnt++;
                repeat (hold) begin
                    @(negedge clk);
                    chk(res_valid && res_data == e, "R8 hold", res_data, e);
                end
                res_ready = 1'b1;
                @(negedge clk);
                res_ready = 1'b0;
                chk(!res_valid && start_ready, "R8 release", res_valid, 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(start_ready == 1'b1, "R1 start_ready", start_ready, 1);
        chk(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
        chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        run_job(1, 0, 1'b0);          // R5
        run_job(2, 1, 1'b0);          // R3
        run_job(3, VL - 1, 1'b0);     // R3
        run_job(4, VL, 1'b0);         // R4
        run_job(5, 3 * VL + 5, 1'b0); // R3, R4
        run_job(6, 29, 1'b0);         // R2: same length again
        run_job(7, 0, 1'b0);          // R2, R5 after non-zero job
        run_job(8, 65540, 1'b1);      // R6 wrap
        while (exp_q.size() != 0 || res_valid) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule